// File: doc/BRIEF.md
# Addressing-Mode Accumulate Unit

This block executes one kind of operation, an accumulating add `Rd <= Rd + operand`. Each command selects how the operand is obtained. It can come from a second register or from a sign-extended 16-bit constant. It can also come from memory, addressed through a register, through a register plus a sign-extended 16-bit offset, or through a pointer that is first fetched from memory. The unit holds its own bank of 32 general registers, each 64 bits wide, and reaches a 64-bit word memory through a request/acknowledge read port.

A sequencer accepts a command only while it is idle. It evaluates the effective address and then makes zero, one or two dependent reads. It finishes with a one-cycle completion pulse or a one-cycle fault pulse. Any word address whose three low bits are not zero is refused. A debug port reads any register combinationally, so results can be inspected after each command.

Top module: `amf_unit`

## Requirements
- R1: After reset, `ready` is high, `done`, `error` and `mem_req` are low, and every register reads zero on the debug port.
- R2: Mode code 0 (register) sets Rd to Rd + Rs with no memory read, and `done` pulses in the first cycle after the command is accepted.
- R3: Mode code 1 (immediate) sets Rd to Rd + the 16-bit constant sign-extended to 64 bits, with no memory read, and `done` pulses in the first cycle after acceptance.
- R4: Mode code 2 (register indirect) makes exactly one read at address Rs and sets Rd to Rd + the returned word.
- R5: Mode code 3 (displacement) makes exactly one read at Rs + the sign-extended 16-bit offset and sets Rd to Rd + the returned word.
- R6: Mode code 4 (memory indirect) reads address Rs, then reads the returned word used as an address, and sets Rd to Rd + the second word.
- R7: Register 0 always reads zero. A command targeting it still signals `done`, but its result is discarded.
- R8: If the effective address in modes 2, 3 or 4 has nonzero bits [2:0], `error` pulses in the first cycle after acceptance, no read is made and Rd is unchanged.
- R9: In mode 4, if the fetched pointer has nonzero bits [2:0], `error` pulses in the cycle of the first acknowledge, no second read is made and Rd is unchanged.
- R10: Mode codes 5, 6 and 7 pulse `error` in the first cycle after acceptance with no read and no register change.
- R11: `mem_req` is low while idle. Once raised, it stays high with an unchanged `mem_addr` until the cycle in which `mem_ack` is high, and `mem_rdata` is taken in that cycle. Every address presented has bits [2:0] zero.
- R12: `ready` is low from acceptance until after the completion cycle, and `cmd_valid` is ignored while it is low. `done` and `error` are never high together and each lasts one cycle.
- R13: All additions, both address and accumulate, wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present; taken when `ready` is high |
| cmd_mode | input | 3 | Operand mode code (0..4 valid) |
| cmd_rd | input | 5 | Destination and accumulator register index |
| cmd_rs | input | 5 | Source or base register index |
| cmd_imm | input | 16 | Constant or offset, sign-extended |
| ready | output | 1 | Unit idle and able to take a command |
| done | output | 1 | One-cycle pulse: result written |
| error | output | 1 | One-cycle pulse: command aborted |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Read byte address, word aligned |
| mem_ack | input | 1 | Read acknowledge; data valid this cycle |
| mem_rdata | input | 64 | Read data |
| dbg_idx | input | 5 | Debug register index |
| dbg_data | output | 64 | Debug register contents |

## Verification
Two events can fall in the same cycle: a memory acknowledge and the completion of the command. The acknowledge may also arrive in the very cycle the request first rises, and in memory-indirect mode the second request can start in the cycle right after the first acknowledge. The bench sweeps every mode code over many register and offset combinations with acknowledge latencies of zero, one and two cycles. Against its own model of registers and memory contents, it judges the outcome pulse, the count and addresses of reads, the latency of the register-only paths and the final register value. In alternate commands it also keeps `cmd_valid` high with a different command while the unit is busy, and checks that this does not disturb a register.

// File: rtl/amf_pkg.sv
package amf_pkg;

  typedef enum logic [2:0] {
    MODE_REG  = 3'd0,
    MODE_IMM  = 3'd1,
    MODE_RIND = 3'd2,
    MODE_DISP = 3'd3,
    MODE_MIND = 3'd4
  } amf_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_FETCH1,
    ST_FETCH2
  } amf_state_e;

endpackage

// File: rtl/amf_agu.sv
module amf_agu #(
  parameter int XLEN   = 64,
  parameter int ALIGNW = 3
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] ea,
  output logic            misaligned
);

  always_comb begin
    ea         = base + offset;
    misaligned = |ea[ALIGNW-1:0];
  end

endmodule

// File: rtl/amf_regfile.sv
module amf_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [XLEN-1:0] rb_data,
  input  logic [IDXW-1:0] dbg_idx,
  output logic [XLEN-1:0] dbg_data,
  input  logic            we,
  input  logic [IDXW-1:0] wa,
  input  logic [XLEN-1:0] wd
);

  logic [XLEN-1:0] regs_q [NREG];

  // entry 0 is reset and never written, so it stays zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (we && (wa == IDXW'(i))) regs_q[i] <= wd;
      end
    end
  end

  always_comb begin
    ra_data  = regs_q[ra_idx];
    rb_data  = regs_q[rb_idx];
    dbg_data = regs_q[dbg_idx];
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0) |=> regs_q[$past(wa)] == $past(wd));

  assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa == '0) |=> regs_q[0] == '0);

endmodule

// File: rtl/amf_seq.sv
module amf_seq
  import amf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int IMMW = 16,
  localparam int IDXW   = $clog2(NREG),
  localparam int ALIGNW = $clog2(XLEN / 8)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_mode,
  input  logic [IDXW-1:0] cmd_rd,
  input  logic [IDXW-1:0] cmd_rs,
  input  logic [IMMW-1:0] cmd_imm,
  output logic            ready,
  output logic            done,
  output logic            error,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [IDXW-1:0] rs_idx,
  input  logic [XLEN-1:0] rs_data,
  output logic [IDXW-1:0] rd_idx,
  input  logic [XLEN-1:0] rd_data,
  output logic            we,
  output logic [IDXW-1:0] wa,
  output logic [XLEN-1:0] wd
);

  amf_state_e      state_q, state_d;
  logic [2:0]      mode_q;
  logic [IDXW-1:0] rd_q, rs_q;
  logic [XLEN-1:0] imm_q, addr_q, addr_d;
  logic            load_cmd, addr_en;
  logic [XLEN-1:0] agu_off, ea;
  logic            ea_mis, ptr_mis;
  logic [XLEN-1:0] operand;

  assign agu_off = (mode_q == MODE_DISP) ? imm_q : '0;

  amf_agu #(.XLEN(XLEN), .ALIGNW(ALIGNW)) u_agu (
    .base       (rs_data),
    .offset     (agu_off),
    .ea         (ea),
    .misaligned (ea_mis)
  );

  assign ptr_mis = |mem_rdata[ALIGNW-1:0];

  always_comb begin
    case (mode_q)
      MODE_REG: operand = rs_data;
      MODE_IMM: operand = imm_q;
      default:  operand = mem_rdata;
    endcase
  end

  // next-state process
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    addr_en  = 1'b0;
    load_cmd = 1'b0;
    we       = 1'b0;
    done     = 1'b0;
    error    = 1'b0;
    mem_req  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          load_cmd = 1'b1;
          state_d  = ST_EVAL;
        end
      end
      ST_EVAL: begin
        state_d = ST_IDLE;
        case (mode_q)
          MODE_REG, MODE_IMM: begin
            we   = 1'b1;
            done = 1'b1;
          end
          MODE_RIND, MODE_DISP, MODE_MIND: begin
            if (ea_mis) begin
              error = 1'b1;
            end else begin
              addr_d  = ea;
              addr_en = 1'b1;
              state_d = ST_FETCH1;
            end
          end
          default: error = 1'b1;
        endcase
      end
      ST_FETCH1: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          state_d = ST_IDLE;
          if (mode_q == MODE_MIND) begin
            if (ptr_mis) begin
              error = 1'b1;
            end else begin
              addr_d  = mem_rdata;
              addr_en = 1'b1;
              state_d = ST_FETCH2;
            end
          end else begin
            we   = 1'b1;
            done = 1'b1;
          end
        end
      end
      ST_FETCH2: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          we      = 1'b1;
          done    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      rd_q    <= '0;
      rs_q    <= '0;
      imm_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_cmd) begin
        mode_q <= cmd_mode;
        rd_q   <= cmd_rd;
        rs_q   <= cmd_rs;
        imm_q  <= {{(XLEN-IMMW){cmd_imm[IMMW-1]}}, cmd_imm};
      end
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign ready    = (state_q == ST_IDLE);
  assign mem_addr = addr_q;
  assign rs_idx   = rs_q;
  assign rd_idx   = rd_q;
  assign wa       = rd_q;
  assign wd       = rd_data + operand;

  assert_hold_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req);

  assert_aligned_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[ALIGNW-1:0] == '0));

  assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !error);

  assert_short_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> (!done && !error && ready));

  assert_no_write_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !we);

endmodule

// File: rtl/amf_unit.sv
module amf_unit #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int IMMW = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_mode,
  input  logic [IDXW-1:0] cmd_rd,
  input  logic [IDXW-1:0] cmd_rs,
  input  logic [IMMW-1:0] cmd_imm,
  output logic            ready,
  output logic            done,
  output logic            error,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic [IDXW-1:0] dbg_idx,
  output logic [XLEN-1:0] dbg_data
);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [IDXW-1:0] rs_idx, rd_idx, wa;
  logic [XLEN-1:0] rs_data, rd_data, wd;
  logic            we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  amf_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ra_idx   (rs_idx),
    .ra_data  (rs_data),
    .rb_idx   (rd_idx),
    .rb_data  (rd_data),
    .dbg_idx  (dbg_idx),
    .dbg_data (dbg_data),
    .we       (we),
    .wa       (wa),
    .wd       (wd)
  );

  amf_seq #(.XLEN(XLEN), .NREG(NREG), .IMMW(IMMW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_mode  (cmd_mode),
    .cmd_rd    (cmd_rd),
    .cmd_rs    (cmd_rs),
    .cmd_imm   (cmd_imm),
    .ready     (ready),
    .done      (done),
    .error     (error),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .rs_idx    (rs_idx),
    .rs_data   (rs_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .we        (we),
    .wa        (wa),
    .wd        (wd)
  );

endmodule

// File: tb/amf_unit_bench.sv
module amf_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_mode = '0;
  logic [4:0]  cmd_rd = '0;
  logic [4:0]  cmd_rs = '0;
  logic [15:0] cmd_imm = '0;
  logic        ready, done, error, mem_req;
  logic [63:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [4:0]  dbg_idx = '0;
  logic [63:0] dbg_data;

  always #10 clk = ~clk;

  amf_unit u_amf_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_rd(cmd_rd), .cmd_rs(cmd_rs), .cmd_imm(cmd_imm), .ready(ready),
    .done(done), .error(error), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  int          ack_delay = 0;
  int          wcnt = 0;
  int          nreads = 0;
  logic [63:0] rd_addr [2];
  logic [63:0] shadow [32];

  function automatic logic [63:0] memv(logic [63:0] a);
    int i = int'(a[8:3]);
    logic [63:0] b;
    case (i % 4)
      0:       b = 64'(((i * 5 + 8) % 64) * 8);
      1:       b = 64'(i * 8 + 3);
      2:       b = 64'hFFFF_FFFF_FFFF_FFF0 + 64'(i);
      default: b = 64'(i) * 64'h0001_0203_0405_0607;
    endcase
    return b ^ {a[63:9], 9'b0};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: acts at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        if (wcnt >= ack_delay) begin
          mem_ack   = 1'b1;
          mem_rdata = memv(mem_addr);
          if (nreads < 2) rd_addr[nreads] = mem_addr;
          nreads++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  task automatic run_cmd(input logic [2:0] m, input logic [4:0] rd, input logic [4:0] rs,
                         input logic [15:0] imm, input bit noise);
    logic [63:0] sx, a1, a2, d, newv;
    bit          exp_err;
    int          exp_reads, cyc;
    logic        done_s, err_s;
    string       tag;
    sx = {{48{imm[15]}}, imm};
    exp_err = 1'b0; exp_reads = 0; a1 = '0; a2 = '0; newv = shadow[rd];
    case (m)
      3'd0: begin tag = "R2"; newv = shadow[rd] + shadow[rs]; end
      3'd1: begin tag = "R3"; newv = shadow[rd] + sx; end
      3'd2, 3'd3, 3'd4: begin
        tag = (m == 3'd2) ? "R4" : (m == 3'd3) ? "R5" : "R6";
        a1 = shadow[rs] + ((m == 3'd3) ? sx : 64'd0);
        if (a1[2:0] != 3'd0) begin
          exp_err = 1'b1; tag = "R8";
        end else begin
          exp_reads = 1; d = memv(a1);
          if (m == 3'd4) begin
            if (d[2:0] != 3'd0) begin
              exp_err = 1'b1; tag = "R9";
            end else begin
              exp_reads = 2; a2 = d; d = memv(a2);
            end
          end
          if (!exp_err) newv = shadow[rd] + d;
        end
      end
      default: begin tag = "R10"; exp_err = 1'b1; end
    endcase
    if (rd == 5'd0) tag = {tag, "/R7"};

    @(negedge clk); #1;
    chk({tag, " ready before command R12"}, 64'(ready), 64'd1);
    cmd_mode = m; cmd_rd = rd; cmd_rs = rs; cmd_imm = imm; cmd_valid = 1'b1;
    nreads = 0;
    @(posedge clk);
    cyc = 0; done_s = 1'b0; err_s = 1'b0;
    forever begin
      @(negedge clk); #1;
      cyc++;
      if (noise) begin
        cmd_mode = 3'd1; cmd_rd = 5'd30; cmd_imm = 16'd1;
      end else begin
        cmd_valid = 1'b0;
      end
      chk({tag, " ready low while busy R12"}, 64'(ready), 64'd0);
      if (done || error) begin
        done_s = done; err_s = error;
        cmd_valid = 1'b0;
        break;
      end
      if (cyc > 40) begin
        cmd_valid = 1'b0;
        chk({tag, " command hung"}, 64'(cyc), 64'd0);
        break;
      end
    end
    chk({tag, " done flag"}, 64'(done_s), 64'(!exp_err));
    chk({tag, " error flag"}, 64'(err_s), 64'(exp_err));
    chk({tag, " read count"}, 64'(nreads), 64'(exp_reads));
    if (exp_reads >= 1) chk({tag, " first read address R11"}, rd_addr[0], a1);
    if (exp_reads == 2) chk({tag, " second read address R6"}, rd_addr[1], a2);
    if (m != 3'd2 && m != 3'd3 && m != 3'd4)
      chk({tag, " latency"}, 64'(cyc), 64'd1);
    if ((m == 3'd2 || m == 3'd3 || m == 3'd4) && exp_err && exp_reads == 0)
      chk({tag, " fault latency R8"}, 64'(cyc), 64'd1);

    @(negedge clk); #1;
    chk({tag, " pulse one cycle R12"}, 64'({done, error}), 64'd0);
    chk({tag, " idle without request R11"}, 64'({ready, mem_req}), 64'b10);
    if (!exp_err && rd != 5'd0) shadow[rd] = newv;
    dbg_idx = rd; #1;
    chk({tag, " register result"}, dbg_data, shadow[rd]);
    if (noise) begin
      dbg_idx = 5'd30; #1;
      chk({tag, " busy command ignored R12"}, dbg_data, shadow[30]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 ready", 64'(ready), 64'd1);
    chk("R1 done/error/req", 64'({done, error, mem_req}), 64'd0);
    for (int i = 0; i < 32; i++) begin
      dbg_idx = 5'(i); #1;
      chk("R1 register zero", dbg_data, 64'd0);
    end

    // preload base registers with immediates
    for (int j = 1; j <= 8; j++) run_cmd(3'd1, 5'(j), 5'd0, 16'(j * 8), 1'b0);
    for (int j = 9; j <= 12; j++) run_cmd(3'd1, 5'(j), 5'd0, 16'(j * 8 + j - 8), 1'b0);
    run_cmd(3'd1, 5'd13, 5'd0, 16'hFFF8, 1'b0);
    run_cmd(3'd1, 5'd14, 5'd0, 16'h8000, 1'b0);

    // R13: wraparound of the accumulate
    run_cmd(3'd1, 5'd20, 5'd0, 16'hFFFF, 1'b0);
    run_cmd(3'd0, 5'd20, 5'd20, 16'h0000, 1'b0);
    run_cmd(3'd1, 5'd20, 5'd0, 16'h0002, 1'b0);
    dbg_idx = 5'd20; #1;
    chk("R13 wrap to zero", dbg_data, 64'd0);

    // R7: writes to register 0 are dropped
    run_cmd(3'd1, 5'd0, 5'd0, 16'h0055, 1'b0);
    run_cmd(3'd2, 5'd0, 5'd4, 16'h0000, 1'b0);

    // sweep over all mode codes, operand choices and ack latencies
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 8; k++) begin
        logic [15:0] imm;
        logic [4:0]  rd;
        case (k)
          0: imm = 16'h0000; 1: imm = 16'h0008; 2: imm = 16'hFFF8; 3: imm = 16'h0003;
          4: imm = 16'h0010; 5: imm = 16'h7FF8; 6: imm = 16'h8000; default: imm = 16'h0028;
        endcase
        rd = (k == 7) ? 5'd0 : 5'(16 + ((k * 3 + m) % 14));
        ack_delay = (k + m) % 3;
        run_cmd(3'(m), rd, 5'(k + 1 + (m % 2) * 5), imm, k[0]);
      end
    end

    // source and destination the same register through memory
    ack_delay = 0;
    run_cmd(3'd1, 5'd25, 5'd0, 16'h0020, 1'b0);
    run_cmd(3'd4, 5'd25, 5'd25, 16'h0000, 1'b1);
    run_cmd(3'd3, 5'd25, 5'd25, 16'hFFF8, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule